// File: doc/BRIEF.md
# Two-Lane Serial ADC Sample Deserializer

This block sits behind the differential receivers of a four-channel, 12-bit analog-to-digital converter. Each channel reaches it on two serial data lanes, a lane pair per channel. All eight lanes share one bit clock, and each lane gives one bit per rising edge (single data rate). A frame line runs alongside the data. Its rising edge marks the first bit of a frame. The block registers all inputs, finds the frame edges and locks to them. It then rebuilds each channel's 12-bit sample from its lane pair using one of three recombination modes, and presents four parallel words to the next processing stage with a one-cycle valid strobe.

The frame lasts 6 bit clocks in the split-byte and interleaved-bit modes, where one sample is carried per frame. It lasts 12 bit clocks in the whole-word mode, where each lane holds a complete sample and the frame therefore carries two samples in time order. Frame tracking is a four-state machine. HUNT waits for any frame edge and moves to FIRST. FIRST moves to SECOND on an edge that arrives exactly one frame length after the previous one. SECOND moves to LOCK on another such edge. In FIRST, SECOND and LOCK, an edge at the wrong spacing returns the machine to FIRST. A full frame length with no edge returns it to HUNT. Samples are delivered only while the machine is in LOCK. The mode input is taken continuously while out of lock. In lock it is taken only at a frame edge, so a frame is never decoded in a mix of two modes.

Top module: `adc_lane_deser`

## Requirements
- R1: After reset, valid_o and locked_o are 0.
- R2: locked_o rises only after the second consecutive frame edge that is spaced exactly one frame length from the one before, so the third edge of a clean stream. The first two frames produce no output.
- R3: Split-byte mode (mode_in 0, and also code 3): per frame (6 bit clocks) lane_a carries sample bits 11..6 and lane_b carries bits 5..0, each most significant bit first.
- R4: Interleaved-bit mode (mode_in 1): per frame (6 bit clocks) lane_a carries the odd bits 11,9,..,1 and lane_b carries the even bits 10,8,..,0, in that order.
- R5: Whole-word mode (mode_in 2): the frame is 12 bit clocks. lane_a carries the earlier sample and lane_b the later, each MSB first. Both are delivered as two sets on consecutive cycles, with the lane_a set first.
- R6: Each assembled set is presented on sample_o, channel c in bits [12c+11:12c], with a valid_o pulse of exactly one cycle. Every frame decoded in lock yields its sets, and no other pulses occur.
- R7: While locked, a change of mode_in takes effect only at the next frame edge. A change and return within a frame has no effect, and a mode change at a frame boundary keeps lock.
- R8: A frame period with no frame edge drops locked_o. No valid_o pulse occurs until lock is regained under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; lanes and frame line sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_in | input | 1 | Frame line; rising edge marks the first bit of a frame |
| lane_a | input | 4 | First serial lane of each channel (bit c = channel c) |
| lane_b | input | 4 | Second serial lane of each channel |
| mode_in | input | 2 | Recombination mode: 0 split-byte, 1 interleaved-bit, 2 whole-word |
| sample_o | output | 48 | Four assembled 12-bit samples, channel c in bits [12c+11:12c] |
| valid_o | output | 1 | One-cycle strobe per assembled set |
| locked_o | output | 1 | Frame lock established |

## Verification
The bench drives ramp samples through every mode. A swapped lane, a reversed bit order or a wrong interleave shows up at once as a mismatched word. It switches modes at frame boundaries while locked and toggles mode_in inside a frame. A design that samples the mode at the wrong time would decode a frame with the wrong recombination or lose lock on the changed frame length. In whole-word mode it checks that the two sets come out in time order and on consecutive cycles. A design that dropped or swapped the held second sample fails there. Finally it removes one frame edge. A design that kept its lock, or that relocked too early, emits sets the scoreboard does not expect.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

    localparam logic [1:0] MODE_BYTE = 2'd0;
    localparam logic [1:0] MODE_BIT  = 2'd1;
    localparam logic [1:0] MODE_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FIRST,
        ST_SECOND,
        ST_LOCK
    } lock_state_e;

endpackage

// File: rtl/adc_frame_lock.sv
module adc_frame_lock
    import adc_deser_pkg::*;
#(
    parameter int SW = 12,
    parameter int CW = $clog2(SW + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_q,
    input  logic [1:0] mode_in,
    output logic       edge_o,
    output logic       last_o,
    output logic       locked_o,
    output logic [1:0] mode_o
);

    lock_state_e   state, state_nx;
    logic          frame_d;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic          spaced, lost;

    assign edge_o = frame_q & ~frame_d;
    assign len    = (mode_o == MODE_WORD) ? CW'(SW) : CW'(SW / 2);
    assign spaced = edge_o && (cnt == len);
    assign lost   = !edge_o && (cnt >= len);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:   if (edge_o) state_nx = ST_FIRST;
            ST_FIRST:  if (spaced) state_nx = ST_SECOND;
                       else if (lost) state_nx = ST_HUNT;
            ST_SECOND: if (spaced) state_nx = ST_LOCK;
                       else if (edge_o) state_nx = ST_FIRST;
                       else if (lost) state_nx = ST_HUNT;
            ST_LOCK:   if (edge_o && !spaced) state_nx = ST_FIRST;
                       else if (lost) state_nx = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        locked_o = (state == ST_LOCK);
        last_o   = !edge_o && (cnt == len - CW'(1));
    end

    // frame history, position counter, mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_d <= 1'b0;
            cnt     <= '0;
            mode_o  <= MODE_BYTE;
        end else begin
            frame_d <= frame_q;
            if (edge_o)          cnt <= CW'(1);
            else if (cnt != '1)  cnt <= cnt + CW'(1);
            if (state != ST_LOCK || edge_o) mode_o <= mode_in;
        end
    end

endmodule

// File: rtl/adc_lane_asm.sv
module adc_lane_asm
    import adc_deser_pkg::*;
#(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_bit,
    input  logic          b_bit,
    input  logic [1:0]    mode,
    output logic [SW-1:0] first_o,
    output logic [SW-1:0] second_o
);

    localparam int HW = SW / 2;

    logic [SW-2:0] sh_a, sh_b;
    logic [SW-1:0] full_a, full_b;

    assign full_a = {sh_a, a_bit};
    assign full_b = {sh_b, b_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_a <= '0;
            sh_b <= '0;
        end else begin
            sh_a <= full_a[SW-2:0];
            sh_b <= full_b[SW-2:0];
        end
    end

    always_comb begin
        second_o = full_b;
        unique case (mode)
            MODE_WORD: first_o = full_a;
            MODE_BIT: begin
                for (int k = 0; k < HW; k++) begin
                    first_o[2*k+1] = full_a[k];
                    first_o[2*k]   = full_b[k];
                end
            end
            default:   first_o = {full_a[HW-1:0], full_b[HW-1:0]};
        endcase
    end

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
    parameter int NCH = 4,
    parameter int SW  = 12,
    parameter int BW  = NCH * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          is_word,
    input  logic [BW-1:0] first_bus,
    input  logic [BW-1:0] second_bus,
    output logic [BW-1:0] sample_o,
    output logic          valid_o
);

    logic [BW-1:0] pend;
    logic          pend_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
            pend     <= '0;
            pend_v   <= 1'b0;
        end else if (fire) begin
            sample_o <= first_bus;
            valid_o  <= 1'b1;
            pend     <= second_bus;
            pend_v   <= is_word;
        end else if (pend_v) begin
            sample_o <= pend;
            valid_o  <= 1'b1;
            pend_v   <= 1'b0;
        end else begin
            valid_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
    import adc_deser_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_in,
    input  logic [NCH-1:0]    lane_a,
    input  logic [NCH-1:0]    lane_b,
    input  logic [1:0]        mode_in,
    output logic [NCH*SW-1:0] sample_o,
    output logic              valid_o,
    output logic              locked_o
);

    localparam int BW = NCH * SW;

    logic [NCH-1:0] a_q, b_q;
    logic           frame_q;
    logic           edge_w, last_w;
    logic [1:0]     mode_w;
    logic [BW-1:0]  first_bus, second_bus;

    // capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            frame_q <= 1'b0;
        end else begin
            a_q     <= lane_a;
            b_q     <= lane_b;
            frame_q <= frame_in;
        end
    end

    adc_frame_lock #(.SW(SW)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_q  (frame_q),
        .mode_in  (mode_in),
        .edge_o   (edge_w),
        .last_o   (last_w),
        .locked_o (locked_o),
        .mode_o   (mode_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        adc_lane_asm #(.SW(SW)) u_asm (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_bit    (a_q[c]),
            .b_bit    (b_q[c]),
            .mode     (mode_w),
            .first_o  (first_bus[c*SW +: SW]),
            .second_o (second_bus[c*SW +: SW])
        );
    end

    adc_out_stage #(.NCH(NCH), .SW(SW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (last_w && locked_o),
        .is_word    (mode_w == MODE_WORD),
        .first_bus  (first_bus),
        .second_bus (second_bus),
        .sample_o   (sample_o),
        .valid_o    (valid_o)
    );

endmodule

// File: rtl/adc_lane_deser_chk.sv
module adc_lane_deser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_o,
    input logic       locked_o,
    input logic       edge_w,
    input logic [1:0] mode_w
);

    // R8: output only while locked
    a_r8_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(locked_o));

    // R2: lock appears only right after a frame edge
    a_r2_lock_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(edge_w));

    // R7: mode held inside a locked frame
    a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !edge_w) |=> $stable(mode_w));

    // R6: never three strobes in a row
    a_r6_no_triple: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |=> !valid_o);

    // R5: back-to-back strobes only from whole-word frames
    a_r5_pair_only_word: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> ($past(mode_w) == 2'd2));

endmodule

bind adc_lane_deser adc_lane_deser_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_o  (valid_o),
    .locked_o (locked_o),
    .edge_w   (edge_w),
    .mode_w   (mode_w)
);

// File: tb/tb_adc_lane_deser.sv
module tb_adc_lane_deser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_in = 1'b0;
    logic [3:0]  lane_a = '0;
    logic [3:0]  lane_b = '0;
    logic [1:0]  mode_in = 2'd0;
    logic [47:0] sample_o;
    logic        valid_o;
    logic        locked_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic [11:0] ramp = 12'h010;

    logic [47:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    adc_lane_deser dut (
        .clk(clk), .rst_n(rst_n), .frame_in(frame_in),
        .lane_a(lane_a), .lane_b(lane_b), .mode_in(mode_in),
        .sample_o(sample_o), .valid_o(valid_o), .locked_o(locked_o)
    );

    task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // driver: pushes expectation, then serializes one frame
    task automatic send_frame(input logic [1:0] md, input bit want, input bit with_edge,
                              input bit glitch, input string tag);
        int len;
        logic [11:0] s0 [4];
        logic [11:0] s1 [4];
        logic [47:0] e0, e1;
        len = (md == 2'd2) ? 12 : 6;
        for (int c = 0; c < 4; c++) begin
            s0[c] = ramp + 12'(c * 293);
            s1[c] = ramp + 12'(c * 293) + 12'h801;
            e0[c*12 +: 12] = s0[c];
            e1[c*12 +: 12] = s1[c];
        end
        ramp = ramp + 12'h0a5;
        if (want) begin
            exp_q.push_back(e0); tag_q.push_back(tag);
            if (md == 2'd2) begin
                exp_q.push_back(e1); tag_q.push_back(tag);
            end
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mode_in  = (glitch && (i == 2 || i == 3)) ? 2'd2 : md;
            frame_in = with_edge && (i < len / 2);
            for (int c = 0; c < 4; c++) begin
                case (md)
                    2'd2: begin lane_a[c] = s0[c][11-i];   lane_b[c] = s1[c][11-i];   end
                    2'd1: begin lane_a[c] = s0[c][11-2*i]; lane_b[c] = s0[c][10-2*i]; end
                    default: begin lane_a[c] = s0[c][11-i]; lane_b[c] = s0[c][5-i];   end
                endcase
            end
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R8 unexpected valid actual=%h expected=none", sample_o);
            end else begin
                logic [47:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(sample_o == e, t, sample_o, e);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(valid_o == 1'b0 && locked_o == 1'b0, "R1", {46'd0, valid_o, locked_o}, 48'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && locked_o == 1'b0, "R1", {46'd0, valid_o, locked_o}, 48'd0);

        // acquire lock in split-byte mode
        send_frame(2'd0, 0, 1, 0, "R2");
        send_frame(2'd0, 0, 1, 0, "R2");
        check(locked_o == 1'b0, "R2", 48'(locked_o), 48'd0);
        send_frame(2'd0, 1, 1, 0, "R3");
        check(locked_o == 1'b1, "R2", 48'(locked_o), 48'd1);
        for (int n = 0; n < 4; n++) send_frame(2'd0, 1, 1, 0, "R3");

        // mode toggled inside a frame is ignored
        send_frame(2'd0, 1, 1, 1, "R7");
        send_frame(2'd0, 1, 1, 1, "R7");

        // boundary switch to interleaved-bit
        send_frame(2'd1, 1, 1, 0, "R7");
        for (int n = 0; n < 4; n++) send_frame(2'd1, 1, 1, 0, "R4");
        check(locked_o == 1'b1, "R7", 48'(locked_o), 48'd1);

        // boundary switch to whole-word
        send_frame(2'd2, 1, 1, 0, "R7");
        for (int n = 0; n < 4; n++) send_frame(2'd2, 1, 1, 0, "R5");
        check(locked_o == 1'b1, "R7", 48'(locked_o), 48'd1);

        // back to split-byte, code 3 alias
        send_frame(2'd0, 1, 1, 0, "R7");
        send_frame(2'd3, 1, 1, 0, "R3");
        send_frame(2'd0, 1, 1, 0, "R3");

        // missing frame edge
        send_frame(2'd0, 0, 0, 0, "R8");
        check(locked_o == 1'b0, "R8", 48'(locked_o), 48'd0);
        send_frame(2'd0, 0, 1, 0, "R8");
        send_frame(2'd0, 0, 1, 0, "R8");
        check(locked_o == 1'b0, "R8", 48'(locked_o), 48'd0);
        send_frame(2'd0, 1, 1, 0, "R8");
        check(locked_o == 1'b1, "R8", 48'(locked_o), 48'd1);
        send_frame(2'd1, 1, 1, 0, "R4");

        @(negedge clk);
        frame_in = 1'b0; lane_a = '0; lane_b = '0;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6", 48'(exp_q.size()), 48'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule